// File: doc/BRIEF.md
# Selectable Comma Character Framer

This block finds the 10-bit character boundary in a recovered serial stream that arrives one bit per clock. It shifts every incoming bit into a 10-bit window and compares that window against a framing pattern. A static two-bit select chooses the pattern: either the 7-bit comma prefix or the complete K28.5 character. Both disparity forms of the chosen pattern are accepted.

When a match is seen while reframing is allowed, the block records the bit phase at which the matching character ended. From then on it hands out one aligned character every ten clocks at that phase, and it raises a locked flag. The reframe enable may arrive from any clock domain, so it passes through a synchronizer before use. While it is low, the recorded phase is frozen and patterns at other phases have no effect. A one-cycle realign strobe marks every capture that sets a new phase, including the first lock.

Top module: `comma_framer`

## Requirements
- R1: While rst_n is low, char_valid, realign and locked are 0 and char_out is all zeros.
- R2: With frame_sel = 2'b01 (short mode), a window whose first seven received bits are 0011111 or 1100000 is a framing match, whatever its last three bits are.
- R3: With frame_sel = 2'b10 (full mode), only the complete characters 0011111010 and 1100000101 (first-received bit written leftmost) are a match, so a comma character with a different tail does not align the block.
- R4: The reserved test level frame_sel = 2'b00 and the unused code 2'b11 both behave exactly as full mode.
- R5: char_out[9] holds the first-received bit of a character. char_valid is high for one cycle, in the clock after the last bit of that character was sampled. The first strobe after a capture carries the matching character itself, and char_valid stays low while unlocked.
- R6: Once aligned, char_valid recurs every 10 clocks, and the characters it presents are the consecutive 10-bit groups of the stream that follow the matching one.
- R7: reframe_en is synchronized over two clocks. While the synchronized enable is low, a framing pattern at another phase changes neither the phase, nor the realign output, nor the locked flag.
- R8: realign pulses for one cycle, together with char_valid, whenever a capture sets a phase different from the held one or locks for the first time. A match at the current phase produces no pulse.
- R9: locked stays high from the first capture until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial data bit, one per clock |
| reframe_en | input | 1 | Asynchronous, active-high permission to realign |
| frame_sel | input | 2 | Pattern select: 01 short comma, 10 full K28.5, 00/11 treated as full |
| char_out | output | 10 | Aligned character, first-received bit in the MSB |
| char_valid | output | 1 | One-cycle strobe when char_out is updated |
| realign | output | 1 | One-cycle strobe on a phase change or first lock |
| locked | output | 1 | A phase has been captured since reset |

## Verification
A corrupted phase register shows at the ports within ten clocks, as a strobe gap other than ten or as characters sliced across the wrong boundary. A broken pattern comparator or mode decode shows as a missing lock, or as a lock on a character the selected mode must reject, within one clock of that character completing. An enable path that leaks or ignores the synchronizer shows as a realign strobe during a disabled stretch, or a missed realign after re-enable, a few clocks after the misplaced comma.

// File: rtl/comma_framer_pkg.sv
package comma_framer_pkg;

  localparam int CF_CHAR_W  = 10;
  localparam int CF_COMMA_W = 7;

  typedef enum logic [1:0] {
    SEL_TEST  = 2'b00,
    SEL_SHORT = 2'b01,
    SEL_FULL  = 2'b10,
    SEL_SPARE = 2'b11
  } frame_sel_e;

  // comma prefix, both disparity forms, first-received bit leftmost
  localparam logic [CF_COMMA_W-1:0] SHORT_NEG = 7'b0011111;
  localparam logic [CF_COMMA_W-1:0] SHORT_POS = 7'b1100000;
  // complete K28.5 character, both disparity forms
  localparam logic [CF_CHAR_W-1:0]  FULL_NEG  = 10'b0011111010;
  localparam logic [CF_CHAR_W-1:0]  FULL_POS  = 10'b1100000101;

endpackage

// File: rtl/cf_sync.sv
module cf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cf_shifter.sv
module cf_shifter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] win
);
  logic [W-1:0] win_q;
  logic [W-1:0] win_d;

  always_comb win_d = {win_q[W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign win = win_q;
endmodule

// File: rtl/cf_match.sv
module cf_match
  import comma_framer_pkg::*;
#(
  parameter int CHAR_W  = CF_CHAR_W,
  parameter int COMMA_W = CF_COMMA_W
) (
  input  logic [CHAR_W-1:0] win,
  input  frame_sel_e        sel,
  output logic              hit
);
  logic short_hit;
  logic full_hit;

  always_comb begin
    short_hit = (win[CHAR_W-1 -: COMMA_W] == SHORT_NEG) ||
                (win[CHAR_W-1 -: COMMA_W] == SHORT_POS);
    full_hit  = (win == FULL_NEG) || (win == FULL_POS);
    // reserved and spare codes fall back to the full-character mode
    hit       = (sel == SEL_SHORT) ? short_hit : full_hit;
  end
endmodule

// File: rtl/cf_align.sv
module cf_align #(
  parameter int CHAR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] win,
  input  logic              hit,
  input  logic              en,
  output logic [CHAR_W-1:0] char_out,
  output logic              char_valid,
  output logic              realign,
  output logic              locked
);
  localparam int CNT_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic [CNT_W-1:0]  phase_q, phase_d;
  logic              lock_q,  lock_d;
  logic              valid_q, valid_d;
  logic              moved_q, moved_d;
  logic [CHAR_W-1:0] char_q,  char_d;
  logic              capture;
  logic              boundary;
  logic              char_en;

  always_comb begin
    capture  = hit && en;
    boundary = capture || (lock_q && (cnt_q == phase_q));
    cnt_d    = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    phase_d  = capture ? cnt_q : phase_q;
    lock_d   = lock_q || capture;
    moved_d  = capture && (!lock_q || (cnt_q != phase_q));
    valid_d  = boundary;
    char_en  = boundary;
    char_d   = win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= '0;
      lock_q  <= 1'b0;
      valid_q <= 1'b0;
      moved_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      lock_q  <= lock_d;
      valid_q <= valid_d;
      moved_q <= moved_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       char_q <= '0;
    else if (char_en) char_q <= char_d;
  end

  assign char_out   = char_q;
  assign char_valid = valid_q;
  assign realign    = moved_q;
  assign locked     = lock_q;
endmodule

// File: rtl/comma_framer.sv
module comma_framer
  import comma_framer_pkg::*;
#(
  parameter int CHAR_W      = CF_CHAR_W,
  parameter int COMMA_W     = CF_COMMA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              reframe_en,
  input  logic [1:0]        frame_sel,
  output logic [CHAR_W-1:0] char_out,
  output logic              char_valid,
  output logic              realign,
  output logic              locked
);
  logic              en_s;
  logic [CHAR_W-1:0] win;
  logic              hit;
  frame_sel_e        sel_e;

  assign sel_e = frame_sel_e'(frame_sel);

  cf_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(reframe_en), .q(en_s)
  );

  cf_shifter #(.W(CHAR_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .din(rx_bit), .win(win)
  );

  cf_match #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W)) match_i (
    .win(win), .sel(sel_e), .hit(hit)
  );

  cf_align #(.CHAR_W(CHAR_W)) align_i (
    .clk(clk), .rst_n(rst_n), .win(win), .hit(hit), .en(en_s),
    .char_out(char_out), .char_valid(char_valid),
    .realign(realign), .locked(locked)
  );
endmodule

// File: rtl/cf_checker.sv
module cf_checker
  import comma_framer_pkg::*;
#(
  parameter int CHAR_W  = CF_CHAR_W,
  parameter int COMMA_W = CF_COMMA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_s,
  input logic [CHAR_W-1:0] char_out,
  input logic              char_valid,
  input logic              realign,
  input logic              locked
);
  localparam int GW = $clog2(CHAR_W) + 2;
  localparam logic [GW-1:0] GAP = GW'(CHAR_W - 1);
  localparam logic [GW-1:0] TOP = '1;

  logic [GW-1:0] since_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (char_valid) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != TOP) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R5: no character strobe before a phase is held
  p_quiet_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !char_valid);

  // R6: strobes recur every CHAR_W clocks unless a new phase was taken
  p_char_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !realign && seen_q) |-> (since_q == GAP));

  // R7: a new phase is taken only while the synchronized enable was high
  p_realign_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> $past(en_s));

  // R8: realign travels with the strobe of the matching character
  p_realign_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> (char_valid && locked));

  // R2: any realigned character starts with a comma prefix
  p_realign_comma_r2: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> ((char_out[CHAR_W-1 -: COMMA_W] == SHORT_NEG) ||
                 (char_out[CHAR_W-1 -: COMMA_W] == SHORT_POS)));

  // R9: lock is held until reset
  p_locked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

bind comma_framer cf_checker #(.CHAR_W(CHAR_W), .COMMA_W(COMMA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .char_out(char_out),
  .char_valid(char_valid), .realign(realign), .locked(locked)
);

// File: tb/comma_framer_tb_top.sv
`timescale 1ns/1ps
module comma_framer_tb_top;
  localparam logic [9:0] KA   = 10'b0011111010;
  localparam logic [9:0] KB   = 10'b1100000101;
  localparam logic [9:0] K1A  = 10'b0011111001;
  localparam logic [9:0] K1B  = 10'b1100000110;
  localparam logic [9:0] D215 = 10'b1010101010;
  localparam logic [9:0] D102 = 10'b0101010101;

  // sel[36:35] lead[34:31] c0[30:21] c1[20:11] c2[10:1] lock[0]
  localparam int NV = 8;
  localparam logic [36:0] VEC [NV] = '{
    {2'b01, 4'd3, K1A, D215, D102, 1'b1},
    {2'b01, 4'd6, K1B, D102, D215, 1'b1},
    {2'b10, 4'd2, K1A, D215, D102, 1'b0},
    {2'b10, 4'd5, KA,  D215, D102, 1'b1},
    {2'b10, 4'd0, KB,  D102, D215, 1'b1},
    {2'b00, 4'd7, KB,  D215, D102, 1'b1},
    {2'b11, 4'd1, KA,  D102, D215, 1'b1},
    {2'b00, 4'd4, K1B, D215, D102, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b0;
  logic       reframe_en = 1'b0;
  logic [1:0] frame_sel = 2'b01;
  logic [9:0] char_out;
  logic       char_valid, realign, locked;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, last_cyc = 0, gap_bad = 0;
  int n_got = 0, n_realign = 0;
  bit have_last = 1'b0, done = 1'b0;
  logic [9:0] got [128];

  always #2.5 clk = ~clk;

  comma_framer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .reframe_en(reframe_en),
    .frame_sel(frame_sel), .char_out(char_out), .char_valid(char_valid),
    .realign(realign), .locked(locked)
  );

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) have_last = 1'b0;
    else begin
      if (char_valid) begin
        got[n_got % 128] = char_out;
        if (have_last && !realign && (cyc - last_cyc) != 10) gap_bad++;
        last_cyc  = cyc;
        have_last = 1'b1;
        n_got++;
      end
      if (realign) n_realign++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
  endtask

  task automatic send_char(input logic [9:0] c);
    for (int i = 9; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic settle();
    send_bit(1'b0); send_bit(1'b1);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] sel, input logic en);
    @(negedge clk);
    rst_n = 1'b0; rx_bit = 1'b0; frame_sel = sel; reframe_en = en;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic int got_at(input int idx);
    return int'(got[idx % 128]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int b0, r0, g0;
    logic [36:0] v;
    string tag;

    // R1: reset state while the input toggles
    rst_n = 1'b0; reframe_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rx_bit = i[0];
    end
    @(negedge clk);
    chk("R1 char_valid", int'(char_valid), 0);
    chk("R1 realign",    int'(realign),    0);
    chk("R1 locked",     int'(locked),     0);
    chk("R1 char_out",   int'(char_out),   0);

    // vector table: one stream per entry
    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      tag = (v[36:35] == 2'b01) ? "R2" : (v[36:35] == 2'b10) ? "R3" : "R4";
      do_reset(v[36:35], 1'b1);
      b0 = n_got; r0 = n_realign;
      for (int i = 0; i < int'(v[34:31]); i++) send_bit(i[0]);
      send_char(v[30:21]);
      send_char(v[20:11]);
      send_char(v[10:1]);
      settle();
      chk({tag, " strobe count"}, n_got - b0, v[0] ? 3 : 0);
      chk({tag, " locked"}, int'(locked), int'(v[0]));
      if (v[0]) begin
        chk("R5 first char", got_at(b0),     int'(v[30:21]));
        chk("R6 second char", got_at(b0 + 1), int'(v[20:11]));
        chk("R6 third char",  got_at(b0 + 2), int'(v[10:1]));
        chk("R8 one pulse",   n_realign - r0, 1);
      end
    end

    // directed: same-phase match, disabled stretch, re-enable
    do_reset(2'b01, 1'b1);
    b0 = n_got; r0 = n_realign;
    send_bit(1'b0); send_bit(1'b1);
    send_char(KA); send_char(D215); send_char(KA); send_char(D102);
    settle();
    chk("R8 same phase no pulse", n_realign - r0, 1);
    chk("R6 repeated comma", got_at(b0 + 2), int'(KA));

    reframe_en = 1'b0;
    send_char(D215); send_char(D102);
    g0 = n_got; r0 = n_realign;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    send_char(KA); send_char(D215); send_char(D102);
    settle();
    chk("R7 no realign when disabled", n_realign - r0, 0);
    chk("R9 locked held", int'(locked), 1);
    begin
      int seen_comma = 0;
      for (int i = g0; i < n_got; i++) if (got_at(i) == int'(KA)) seen_comma++;
      chk("R7 phase kept", seen_comma, 0);
    end

    reframe_en = 1'b1;
    send_char(D215); send_char(D102);
    r0 = n_realign;
    send_char(KA); send_char(D215);
    settle();
    chk("R8 pulse on new phase", n_realign - r0, 1);
    chk("R5 comma after realign", got_at(n_got - 2), int'(KA));
    chk("R6 char after realign",  got_at(n_got - 1), int'(D215));
    chk("R6 strobe spacing", gap_bad, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule